// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block connects two data buses, A and B, and holds one storage register for each direction. Each direction can forward either the live value on its source bus or the value it last captured, inverted bit by bit, onto the opposite bus. The block is split into independent sections of `WIDTH` bits, `SECTIONS` of them, with eight bits and two sections by default. Every section has its own output enable, direction, pair of capture clocks and pair of source selects. Driving the same controls on every section makes the sections act as one wide path.

Bus pins are modelled as separate input, output and output-enable vectors, so the block synthesizes as plain logic. A pad ring or a wrapper turns each triple into a tri-state pin. In section `s`, data bits `[s*WIDTH +: WIDTH]` and control bit `[s]` belong together.

Captures take place on every rising edge of a section's capture clocks, whatever the enables are doing. A register loaded while both buses are isolated can be driven out later. The live/stored selector uses a sum-of-products form with a consensus term, so switching the select between two equal values cannot produce a transient on the driven bus.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `ab_clk[s]`, the A-to-B register of section `s` loads `a_in` of that section, whatever the values of `oe_n` and `dir`.
- R2: On each rising edge of `ba_clk[s]`, the B-to-A register of section `s` loads `b_in` of that section, whatever the values of `oe_n` and `dir`.
- R3: While `oe_n[s]` is 1, `a_oe[s]` and `b_oe[s]` are both 0, and both registers of that section still load on their own clock edges.
- R4: While `oe_n[s]` is 0 and `dir[s]` is 0, `a_oe[s]` is 1 and `b_oe[s]` is 0. With `sel_ba[s]` at 0, `a_out` of the section equals the bitwise complement of that section's live `b_in`.
- R5: With `sel_ba[s]` at 1, `a_out` of the section equals the bitwise complement of the B-to-A register.
- R6: While `oe_n[s]` is 0 and `dir[s]` is 1, `b_oe[s]` is 1 and `a_oe[s]` is 0. With `sel_ab[s]` at 0, `b_out` of the section equals the bitwise complement of that section's live `a_in`.
- R7: With `sel_ab[s]` at 1, `b_out` of the section equals the bitwise complement of the A-to-B register.
- R8: `a_oe[s]` and `b_oe[s]` are never both 1.
- R9: A section's controls, clocks and bus inputs have no effect on another section's outputs or registers.
- R10: While `rst_n` is 0, a rising capture edge clears that register to all zeros, so a stored value then drives as all ones.
- R11: When the live and stored values of a direction are equal, toggling that direction's select leaves its output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, sampled on the capture clock edges |
| oe_n | input | SECTIONS | Active-low output enable per section |
| dir | input | SECTIONS | Direction per section: 1 drives B, 0 drives A |
| ab_clk | input | SECTIONS | Capture clock of the A-to-B register per section |
| ba_clk | input | SECTIONS | Capture clock of the B-to-A register per section |
| sel_ab | input | SECTIONS | B-bus source: 0 live A data, 1 stored A-to-B data |
| sel_ba | input | SECTIONS | A-bus source: 0 live B data, 1 stored B-to-A data |
| a_in | input | SECTIONS*WIDTH | Value seen on the A bus |
| a_out | output | SECTIONS*WIDTH | Value for the A bus (inverted B-side data) |
| a_oe | output | SECTIONS | Drive enable of the A bus per section |
| b_in | input | SECTIONS*WIDTH | Value seen on the B bus |
| b_out | output | SECTIONS*WIDTH | Value for the B bus (inverted A-side data) |
| b_oe | output | SECTIONS | Drive enable of the B bus per section |

## Verification
The bench loads registers while both buses are isolated and then enables the outputs to read those registers. A design that gated capture with the enables would drive stale data at that point. With live and stored data set to different values, it switches the selects and changes the live inputs without a clock edge, which catches swapped selects, a missing inversion and a register that follows the bus directly. It clocks only one section while giving the other different controls and data, so a crossed clock or slice shows up as a changed neighbour. It also toggles a select with equal live and stored values, and reads the stored path right after reset to confirm the all-ones drive.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input  logic                      rst_n,
  input  logic [SECTIONS-1:0]       oe_n,
  input  logic [SECTIONS-1:0]       dir,
  input  logic [SECTIONS-1:0]       ab_clk,
  input  logic [SECTIONS-1:0]       ba_clk,
  input  logic [SECTIONS-1:0]       sel_ab,
  input  logic [SECTIONS-1:0]       sel_ba,
  input  logic [SECTIONS*WIDTH-1:0] a_in,
  output logic [SECTIONS*WIDTH-1:0] a_out,
  output logic [SECTIONS-1:0]       a_oe,
  input  logic [SECTIONS*WIDTH-1:0] b_in,
  output logic [SECTIONS*WIDTH-1:0] b_out,
  output logic [SECTIONS-1:0]       b_oe
);
  localparam int TOTAL = SECTIONS * WIDTH;

  logic [TOTAL-1:0] ab_q;
  logic [TOTAL-1:0] ba_q;

  for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
    logic [WIDTH-1:0] q_ab;
    logic [WIDTH-1:0] q_ba;
    logic [WIDTH-1:0] s_ab;
    logic [WIDTH-1:0] s_ba;
    logic [WIDTH-1:0] live_a;
    logic [WIDTH-1:0] live_b;

    assign live_a = a_in[g*WIDTH +: WIDTH];
    assign live_b = b_in[g*WIDTH +: WIDTH];

    always_ff @(posedge ab_clk[g]) begin
      if (!rst_n) q_ab <= '0;
      else        q_ab <= live_a;
    end

    always_ff @(posedge ba_clk[g]) begin
      if (!rst_n) q_ba <= '0;
      else        q_ba <= live_b;
    end

    assign s_ab = {WIDTH{sel_ab[g]}};
    assign s_ba = {WIDTH{sel_ba[g]}};

    // consensus term keeps the output steady while the select moves between equal inputs
    assign b_out[g*WIDTH +: WIDTH] = ~((live_a & ~s_ab) | (q_ab & s_ab) | (live_a & q_ab));
    assign a_out[g*WIDTH +: WIDTH] = ~((live_b & ~s_ba) | (q_ba & s_ba) | (live_b & q_ba));

    assign b_oe[g] = ~oe_n[g] &  dir[g];
    assign a_oe[g] = ~oe_n[g] & ~dir[g];

    assign ab_q[g*WIDTH +: WIDTH] = q_ab;
    assign ba_q[g*WIDTH +: WIDTH] = q_ba;
  end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input logic                      rst_n,
  input logic [SECTIONS-1:0]       oe_n,
  input logic [SECTIONS-1:0]       ab_clk,
  input logic [SECTIONS-1:0]       ba_clk,
  input logic [SECTIONS-1:0]       sel_ab,
  input logic [SECTIONS-1:0]       sel_ba,
  input logic [SECTIONS*WIDTH-1:0] a_in,
  input logic [SECTIONS*WIDTH-1:0] b_in,
  input logic [SECTIONS*WIDTH-1:0] a_out,
  input logic [SECTIONS*WIDTH-1:0] b_out,
  input logic [SECTIONS-1:0]       a_oe,
  input logic [SECTIONS-1:0]       b_oe,
  input logic [SECTIONS*WIDTH-1:0] ab_q,
  input logic [SECTIONS*WIDTH-1:0] ba_q
);
  for (genvar g = 0; g < SECTIONS; g++) begin : g_chk
    assert_capture_ab_R1: assert property (@(posedge ab_clk[g]) disable iff (!rst_n)
      rst_n |=> ab_q[g*WIDTH +: WIDTH] == $past(a_in[g*WIDTH +: WIDTH]));

    assert_capture_ba_R2: assert property (@(posedge ba_clk[g]) disable iff (!rst_n)
      rst_n |=> ba_q[g*WIDTH +: WIDTH] == $past(b_in[g*WIDTH +: WIDTH]));

    assert_isolate_R3: assert property (@(posedge ab_clk[g]) disable iff (!rst_n)
      oe_n[g] |-> (!a_oe[g] && !b_oe[g]));

    assert_one_driver_R8: assert property (@(posedge ab_clk[g]) disable iff (!rst_n)
      !(a_oe[g] && b_oe[g]));

    assert_stored_to_a_R5: assert property (@(posedge ba_clk[g]) disable iff (!rst_n)
      (a_oe[g] && sel_ba[g]) |-> a_out[g*WIDTH +: WIDTH] == ~ba_q[g*WIDTH +: WIDTH]);

    assert_stored_to_b_R7: assert property (@(posedge ab_clk[g]) disable iff (!rst_n)
      (b_oe[g] && sel_ab[g]) |-> b_out[g*WIDTH +: WIDTH] == ~ab_q[g*WIDTH +: WIDTH]);
  end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) chk (
  .rst_n(rst_n), .oe_n(oe_n), .ab_clk(ab_clk), .ba_clk(ba_clk),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
  .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2;
  localparam int W = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic [S-1:0] oe_n, dir, ab_clk, ba_clk, sel_ab, sel_ba;
  logic [S*W-1:0] a_in, b_in, a_out, b_out;
  logic [S-1:0] a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;

  bus_xcvr_reg #(.SECTIONS(S), .WIDTH(W)) uut (
    .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .ab_clk(ab_clk), .ba_clk(ba_clk),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_ab(input int s);
    @(negedge clk); ab_clk[s] = 1'b1;
    @(negedge clk); ab_clk[s] = 1'b0;
    #1;
  endtask

  task automatic pulse_ba(input int s);
    @(negedge clk); ba_clk[s] = 1'b1;
    @(negedge clk); ba_clk[s] = 1'b0;
    #1;
  endtask

  task automatic settle;
    #2;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    a_in = '1; b_in = '1;
    for (int s = 0; s < S; s++) begin pulse_ab(s); pulse_ba(s); end
    rst_n = 1'b1;
    for (int s = 0; s < S; s++) begin
      oe_n[s] = 1'b0; dir[s] = 1'b0; sel_ba[s] = 1'b1; settle;
      check("R10 a_oe", {7'b0, a_oe[s]}, 8'h01);
      check("R10 stored B->A after reset", a_out[s*W +: W], 8'hFF);
      dir[s] = 1'b1; sel_ab[s] = 1'b1; settle;
      check("R10 stored A->B after reset", b_out[s*W +: W], 8'hFF);
    end
  endtask

  task automatic t_isolation;
    for (int s = 0; s < S; s++) begin
      oe_n[s] = 1'b1; dir[s] = 1'b0; settle;
      check("R3 oe both low dir0", {6'b0, a_oe[s], b_oe[s]}, 8'h00);
      dir[s] = 1'b1; settle;
      check("R3 oe both low dir1", {6'b0, a_oe[s], b_oe[s]}, 8'h00);
      a_in[s*W +: W] = 8'h5A ^ 8'(s); pulse_ab(s);
      b_in[s*W +: W] = 8'hC3 ^ 8'(s); pulse_ba(s);
      a_in[s*W +: W] = 8'h00; b_in[s*W +: W] = 8'h00;
      oe_n[s] = 1'b0; dir[s] = 1'b1; sel_ab[s] = 1'b1; settle;
      check("R3 R7 isolated A capture driven", b_out[s*W +: W], ~(8'h5A ^ 8'(s)));
      dir[s] = 1'b0; sel_ba[s] = 1'b1; settle;
      check("R3 R5 isolated B capture driven", a_out[s*W +: W], ~(8'hC3 ^ 8'(s)));
    end
  endtask

  task automatic t_live_ab;
    for (int s = 0; s < S; s++) begin
      oe_n[s] = 1'b0; dir[s] = 1'b1; sel_ab[s] = 1'b0;
      a_in[s*W +: W] = 8'h0F; settle;
      check("R6 b_oe", {6'b0, a_oe[s], b_oe[s]}, 8'h01);
      check("R6 live A->B", b_out[s*W +: W], 8'hF0);
      a_in[s*W +: W] = 8'h81; settle;
      check("R6 live A->B follows input", b_out[s*W +: W], 8'h7E);
    end
  endtask

  task automatic t_live_ba;
    for (int s = 0; s < S; s++) begin
      oe_n[s] = 1'b0; dir[s] = 1'b0; sel_ba[s] = 1'b0;
      b_in[s*W +: W] = 8'h33; settle;
      check("R4 R8 a_oe only", {6'b0, a_oe[s], b_oe[s]}, 8'h02);
      check("R4 live B->A", a_out[s*W +: W], 8'hCC);
      b_in[s*W +: W] = 8'h96; settle;
      check("R4 live B->A follows input", a_out[s*W +: W], 8'h69);
    end
  endtask

  task automatic t_stored_vs_live;
    for (int s = 0; s < S; s++) begin
      oe_n[s] = 1'b0; dir[s] = 1'b1;
      a_in[s*W +: W] = 8'h11; pulse_ab(s);
      a_in[s*W +: W] = 8'h22;
      sel_ab[s] = 1'b1; settle;
      check("R7 stored A->B", b_out[s*W +: W], 8'hEE);
      sel_ab[s] = 1'b0; settle;
      check("R6 live A->B differs", b_out[s*W +: W], 8'hDD);
      sel_ab[s] = 1'b1; pulse_ab(s);
      check("R1 capture while driving", b_out[s*W +: W], 8'hDD);
      dir[s] = 1'b0;
      b_in[s*W +: W] = 8'h44; pulse_ba(s);
      b_in[s*W +: W] = 8'h88;
      sel_ba[s] = 1'b1; settle;
      check("R2 R5 stored B->A", a_out[s*W +: W], 8'hBB);
      sel_ba[s] = 1'b0; settle;
      check("R4 live B->A differs", a_out[s*W +: W], 8'h77);
    end
  endtask

  task automatic t_independent;
    oe_n = '0; dir[0] = 1'b1; dir[1] = 1'b1; sel_ab = '1;
    a_in[W +: W] = 8'hA0; pulse_ab(1);
    a_in[0 +: W] = 8'h3C; a_in[W +: W] = 8'h55; pulse_ab(0);
    check("R9 section0 stored", b_out[0 +: W], 8'hC3);
    check("R9 section1 untouched", b_out[W +: W], 8'h5F);
    oe_n[0] = 1'b1; dir[0] = 1'b0; settle;
    check("R9 section1 oe kept", {7'b0, b_oe[1]}, 8'h01);
    check("R9 section1 data kept", b_out[W +: W], 8'h5F);
  endtask

  task automatic t_equal_switch;
    for (int s = 0; s < S; s++) begin
      oe_n[s] = 1'b0; dir[s] = 1'b1;
      a_in[s*W +: W] = 8'h6B; pulse_ab(s);
      sel_ab[s] = 1'b0; settle;
      check("R11 live equal", b_out[s*W +: W], 8'h94);
      sel_ab[s] = 1'b1; #1;
      check("R11 after toggle", b_out[s*W +: W], 8'h94);
    end
  endtask

  initial begin
    rst_n = 1'b0; oe_n = '1; dir = '0; ab_clk = '0; ba_clk = '0;
    sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0;
    #3;
    t_reset;
    t_isolation;
    t_live_ab;
    t_live_ba;
    t_stored_vs_live;
    t_independent;
    t_equal_switch;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule